// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is a slave control port. It gives an external host read and write access to a bank of 8-bit registers over three wires: an active-low select, a serial clock and one data line that carries traffic in both directions. Every access is one frame of 16 serial clocks. The first byte is the index and the second byte is the data. Both bytes travel most significant bit first. The lowest bit of the index tells the port whether the host is reading or writing. The upper index bits pick one of the registers.

All three pins are treated as asynchronous. They pass through a synchronizer into the system clock domain, and the port acts on the detected edges of the serial clock. The host may leave the serial clock idling low or high when it pulls select low, and both cases sample the same bits. On a read, the port drives the data line only while the data byte is being returned. It releases the line again once select goes high. The pad itself sits outside the block, which exposes the line as separate input, output and output-enable signals.

Top module: `ctl3w_regport`

## Requirements
- R1: After reset every register reads back as 0x00 and the output enable is low.
- R2: A frame with index bit 0 = 0 is a write. Index bits 7..1 form the register address, and the data byte, MSB first, is stored in that register when the 16th rising serial clock edge is seen.
- R3: A frame with index bit 0 = 1 is a read. It returns the addressed register MSB first in the data byte and leaves the register unchanged.
- R4: The output enable stays low during the index byte and during the whole of a write frame. On a read it rises at the falling serial clock edge after the 8th rising edge, and it drops once select is high.
- R5: A frame gives the same result whether the serial clock idles low or high when select falls.
- R6: If select goes high before the 16th rising edge, no register is written.
- R7: Input bits are sampled on the rising serial clock edge. Read data on the line changes only at falling edges, so it stays stable across each rising edge.
- R8: Serial clock edges after the 16th within one select window change no register and do not disturb the returned read byte.
- R9: A write changes only the addressed register. Addresses 0x00 and 0x7F are both reachable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low select from the host, asynchronous |
| sclk | input | 1 | Serial clock from the host, asynchronous |
| sdIn | input | 1 | Data line as seen at the pad |
| sdOut | output | 1 | Value the port drives on the data line |
| sdOe | output | 1 | Output enable for the data line pad |

## Verification
The hardest cases to reach from the ports are a frame cut off a few bits short and a frame that starts with the serial clock idling high. In the second case the first edge inside the select window is a falling edge that must not count as a bit. One transfer task takes the starting clock level and the number of clock pulses as arguments. It can therefore stop after 8, 12 or 15 bits, run past 16, or start from either level, and every outcome is judged afterwards by reading the register back. The same task watches the output enable and the read bit on both sides of each rising edge, so the drive window and the falling-edge update are checked on every read.

// File: rtl/ctl3w_pkg.sv
`timescale 1ns/1ps
package ctl3w_pkg;
  // Per-cycle commands from the sequencer to the datapath.
  typedef struct packed {
    logic shiftIn;   // a serial bit was sampled (rising edge)
    logic bitIn;     // value of the sampled bit
    logic latchIdx;  // last index bit is arriving this cycle
    logic commitWr;  // last data bit of a write is arriving this cycle
    logic shiftRd;   // advance the read byte (falling edge)
    logic idle;      // select is inactive
  } strobe_t;
endpackage

// File: rtl/ctl3w_sync.sv
`timescale 1ns/1ps
module ctl3w_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] qR;
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) qR <= RST_VAL;
          else       qR <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) qR <= RST_VAL;
          else       qR <= g_stage[s-1].qR;
        end
      end
    end
  endgenerate

  assign q = g_stage[STAGES-1].qR;
endmodule

// File: rtl/ctl3w_ctrl.sv
`timescale 1ns/1ps
module ctl3w_ctrl
  import ctl3w_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    csNPin,
  input  logic    sclkPin,
  input  logic    sdPin,
  output strobe_t strb,
  output logic    oe
);
  localparam int TOTAL = IDX_W + DATA_W;
  localparam int CNT_W = $clog2(TOTAL + 1);
  localparam logic [CNT_W-1:0] IDX_LAST   = CNT_W'(IDX_W - 1);
  localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(TOTAL - 1);
  localparam logic [CNT_W-1:0] FRAME_END  = CNT_W'(TOTAL);

  logic [2:0] pins;
  logic csAct, sclkS, bitIn, sclkPrev, rise, fall, riseAct, fallAct, inFrame;
  logic rdMode;
  logic [CNT_W-1:0] bitCnt;

  // select resets to inactive, clock and data to zero
  ctl3w_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) sync_i (
    .clk  (clk),
    .rstN (rstN),
    .d    ({csNPin, sclkPin, sdPin}),
    .q    (pins)
  );

  assign csAct = ~pins[2];
  assign sclkS = pins[1];
  assign bitIn = pins[0];

  // previous clock level is tracked even while idle, so a clock that is
  // already high when select falls never looks like a fresh rising edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkPrev <= 1'b0;
    else       sclkPrev <= sclkS;
  end

  assign rise    = sclkS & ~sclkPrev;
  assign fall    = ~sclkS & sclkPrev;
  assign riseAct = rise & csAct;
  assign fallAct = fall & csAct;
  assign inFrame = (bitCnt != FRAME_END);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      rdMode <= 1'b0;
      oe     <= 1'b0;
    end else if (!csAct) begin
      bitCnt <= '0;
      rdMode <= 1'b0;
      oe     <= 1'b0;
    end else begin
      if (riseAct && inFrame) bitCnt <= bitCnt + 1'b1;
      if (riseAct && bitCnt == IDX_LAST) rdMode <= bitIn;
      if (fallAct && rdMode) oe <= 1'b1;
    end
  end

  always_comb begin
    strb          = '0;
    strb.bitIn    = bitIn;
    strb.idle     = ~csAct;
    strb.shiftIn  = riseAct & inFrame;
    strb.latchIdx = riseAct & (bitCnt == IDX_LAST);
    strb.commitWr = riseAct & (bitCnt == FRAME_LAST) & ~rdMode;
    strb.shiftRd  = fallAct & rdMode & oe & inFrame;
  end
endmodule

// File: rtl/ctl3w_dpath.sv
`timescale 1ns/1ps
module ctl3w_dpath
  import ctl3w_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strb,
  output logic    rdBit
);
  localparam int IDX_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SH_W  = (DATA_W > IDX_W) ? DATA_W : IDX_W;

  logic [SH_W-1:0]   inShift;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] outShift;
  logic [DATA_W-1:0] regs [DEPTH];
  logic [ADDR_W-1:0] idxAddr;
  logic [DATA_W-1:0] wrWord;

  // on the last index bit the shifter still holds the address bits
  assign idxAddr = inShift[ADDR_W-1:0];
  assign wrWord  = {inShift[DATA_W-2:0], strb.bitIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inShift  <= '0;
      addrQ    <= '0;
      outShift <= '0;
    end else begin
      if (strb.shiftIn) inShift <= {inShift[SH_W-2:0], strb.bitIn};
      if (strb.latchIdx) begin
        addrQ    <= idxAddr;
        outShift <= regs[idxAddr];
      end else if (strb.shiftRd) begin
        outShift <= {outShift[DATA_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (strb.commitWr) begin
      regs[addrQ] <= wrWord;
    end
  end

  assign rdBit = outShift[DATA_W-1];
endmodule

// File: rtl/ctl3w_regport.sv
`timescale 1ns/1ps
module ctl3w_regport
  import ctl3w_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sclk,
  input  logic sdIn,
  output logic sdOut,
  output logic sdOe
);
  localparam int IDX_W = ADDR_W + 1;

  strobe_t strb;
  logic    rdBit;

  ctl3w_ctrl #(.IDX_W(IDX_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .csNPin  (csN),
    .sclkPin (sclk),
    .sdPin   (sdIn),
    .strb    (strb),
    .oe      (sdOe)
  );

  ctl3w_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dpath_i (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .rdBit (rdBit)
  );

  assign sdOut = sdOe & rdBit;
endmodule

// File: rtl/ctl3w_regport_chk.sv
`timescale 1ns/1ps
module ctl3w_regport_chk
  import ctl3w_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    sdOe,
  input logic    sdOut,
  input strobe_t strb
);
  // R1: the line is released while reset is held
  a_r1_released_in_reset: assert property (@(posedge clk) !rstN |=> !sdOe);

  // R4: an idle select releases the line on the next cycle
  a_r4_release_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    strb.idle |=> !sdOe);

  // R4: the line is never driven while a write is being committed
  a_r4_no_drive_on_write: assert property (@(posedge clk) disable iff (!rstN)
    sdOe |-> !strb.commitWr);

  // R4: driving starts only inside an active select window
  a_r4_drive_starts_active: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdOe) |-> !$past(strb.idle));

  // R7: while driven, the read bit moves only after a falling-edge shift
  a_r7_out_moves_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    (sdOe && $past(sdOe) && !$stable(sdOut)) |-> $past(strb.shiftRd));

  // R2: index latch, write commit and read shift never coincide
  a_r2_single_event: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.latchIdx, strb.commitWr, strb.shiftRd}));
endmodule

bind ctl3w_regport ctl3w_regport_chk chk_i (
  .clk   (clk),
  .rstN  (rstN),
  .sdOe  (sdOe),
  .sdOut (sdOut),
  .strb  (strb)
);

// File: tb/ctl3w_regport_tb_top.sv
`timescale 1ns/1ps
module ctl3w_regport_tb_top;
  localparam int HALF = 8;  // system clocks per serial half period

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic sdIn = 1'b0;
  logic sdOut, sdOe;
  int nChk = 0;
  int nBad = 0;

  always #2.5 clk = ~clk;

  ctl3w_regport dut_i (
    .clk   (clk),
    .rstN  (rstN),
    .csN   (csN),
    .sclk  (sclk),
    .sdIn  (sdIn),
    .sdOut (sdOut),
    .sdOe  (sdOe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One select window: hi picks the idle clock level, nbits the clock count.
  task automatic xfer(input bit hi, input logic [7:0] idx, input logic [7:0] wd,
                      input int nbits, output logic [7:0] rd);
    logic [15:0] frame;
    bit isRd;
    bit oeBad;
    bit moveBad;
    logic pre;
    frame = {idx, wd};
    isRd = idx[0];
    oeBad = 1'b0;
    moveBad = 1'b0;
    pre = 1'b0;
    rd = '0;
    sclk = hi;
    csN = 1'b1;
    tick(HALF);
    csN = 1'b0;
    tick(HALF);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      tick(HALF);
      sdIn = (i < 16) ? frame[15-i] : 1'b1;
      if (isRd && i >= 8) begin
        if (i < 16) begin
          if (sdOe !== 1'b1) oeBad = 1'b1;
          rd[15-i] = sdOut;
          pre = sdOut;
        end
      end else if (sdOe !== 1'b0) begin
        oeBad = 1'b1;
      end
      tick(HALF);
      sclk = 1'b1;
      tick(HALF);
      if (isRd && i >= 8 && i < 16 && sdOut !== pre) moveBad = 1'b1;
    end
    tick(HALF);
    sclk = hi;
    tick(HALF);
    csN = 1'b1;
    tick(HALF + 4);
    check(!oeBad, "R4 drive window", {7'b0, oeBad}, 8'h00);
    if (isRd && nbits >= 16)
      check(!moveBad, "R7 read bit stable across rising edge", {7'b0, moveBad}, 8'h00);
    check(sdOe === 1'b0, "R4 release after select high", {7'b0, sdOe}, 8'h00);
  endtask

  task automatic wr(input bit hi, input logic [6:0] a, input logic [7:0] d);
    logic [7:0] unused;
    xfer(hi, {a, 1'b0}, d, 16, unused);
  endtask

  task automatic rdChk(input bit hi, input logic [6:0] a, input logic [7:0] exp, input string req);
    logic [7:0] got;
    xfer(hi, {a, 1'b1}, 8'h00, 16, got);
    check(got === exp, req, got, exp);
  endtask

  task automatic t_reset();
    check(sdOe === 1'b0, "R1 output enable after reset", {7'b0, sdOe}, 8'h00);
    rdChk(1'b0, 7'h00, 8'h00, "R1 reg 0x00 after reset");
    rdChk(1'b0, 7'h55, 8'h00, "R1 reg 0x55 after reset");
    rdChk(1'b1, 7'h7F, 8'h00, "R1 reg 0x7F after reset");
  endtask

  task automatic t_writeRead();
    wr(1'b0, 7'h12, 8'hA5);
    rdChk(1'b0, 7'h12, 8'hA5, "R2 write then read 0x12");
    wr(1'b0, 7'h40, 8'h3C);
    rdChk(1'b0, 7'h40, 8'h3C, "R2 write then read 0x40");
    rdChk(1'b0, 7'h40, 8'h3C, "R3 second read unchanged");
  endtask

  task automatic t_idleLevel();
    wr(1'b1, 7'h33, 8'h96);
    rdChk(1'b0, 7'h33, 8'h96, "R5 write with clock idling high");
    wr(1'b0, 7'h34, 8'h69);
    rdChk(1'b1, 7'h34, 8'h69, "R5 read with clock idling high");
  endtask

  task automatic t_abort();
    logic [7:0] x;
    wr(1'b0, 7'h20, 8'h5A);
    xfer(1'b0, {7'h20, 1'b0}, 8'hFF, 12, x);
    rdChk(1'b0, 7'h20, 8'h5A, "R6 abort after 12 bits");
    xfer(1'b1, {7'h20, 1'b0}, 8'h00, 15, x);
    rdChk(1'b0, 7'h20, 8'h5A, "R6 abort after 15 bits");
    xfer(1'b0, {7'h20, 1'b0}, 8'h00, 8, x);
    rdChk(1'b0, 7'h20, 8'h5A, "R6 abort after index only");
  endtask

  task automatic t_extraClocks();
    logic [7:0] x;
    xfer(1'b0, {7'h50, 1'b0}, 8'hC3, 18, x);
    rdChk(1'b0, 7'h50, 8'hC3, "R8 write followed by extra clocks");
    xfer(1'b1, {7'h50, 1'b1}, 8'h00, 20, x);
    check(x === 8'hC3, "R8 read with extra clocks", x, 8'hC3);
  endtask

  task automatic t_isolation();
    wr(1'b0, 7'h7F, 8'h81);
    wr(1'b0, 7'h01, 8'h7E);
    rdChk(1'b0, 7'h7F, 8'h81, "R9 top address");
    rdChk(1'b0, 7'h01, 8'h7E, "R9 address 0x01");
    rdChk(1'b0, 7'h00, 8'h00, "R9 neighbour 0x00 untouched");
    rdChk(1'b0, 7'h7E, 8'h00, "R9 neighbour 0x7E untouched");
    rdChk(1'b0, 7'h02, 8'h00, "R9 neighbour 0x02 untouched");
  endtask

  initial begin
    tick(5);
    rstN = 1'b1;
    tick(4);
    t_reset();
    t_writeRead();
    t_idleLevel();
    t_abort();
    t_extraClocks();
    t_isolation();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule